// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Engine

This block is a synthesizable behavioural model of a three-wire serial EEPROM holding 128 words of 16 bits. A fast system clock oversamples the select, serial clock and data-in lines through two-flop synchronisers, and serial-clock edges are found by comparing consecutive samples. After a start bit, the engine shifts in an opcode, an address field and, for the two write forms, a data word. It then executes one of seven instructions: read, write, erase, erase-all, write-all, enable and disable.

The array lives in registers. An accepted erase or write form arms a pending operation that is launched by the falling edge of select. A down-counter stands in for the self-timed programming time. While it runs, the serial output reports busy and then ready whenever select is high. The serial output is a data bit plus a separate output enable, not a tristate pin. After reset the array reads all ones and programming is locked until an enable instruction arrives.

Top module: `mwire_eeprom`

## Requirements
- R1: A start bit is the first rising serial-clock edge at which select and data-in are both high; earlier rising edges with data-in low change nothing.
- R2: After the start bit come a 2-bit opcode (10 read, 01 write, 11 erase, 00 extended) and an 8-bit address field, all MSB first. The low 7 field bits address the word and the top bit is ignored. For opcode 00 the two top field bits pick the extended function: 11 enable, 00 disable, 10 erase-all, 01 write-all. Read, erase, enable, disable and erase-all are complete on the 11th clock counting the start bit. Write and write-all add 16 data bits, MSB first, and are complete on the 27th.
- R3: After reset, erase, write, erase-all and write-all are ignored until an enable instruction runs. An ignored instruction starts no program cycle, so the output enable stays low when select is raised afterwards.
- R4: A read drives a 0 on the serial output from the rising edge that takes the last address bit, then the 16 bits of the word MSB first, one per following rising edge.
- R5: While select stays high, the rising edge after the 16th bit drives the MSB of the next address with no extra 0, and address 127 is followed by address 0.
- R6: A program cycle begins at the falling edge of select that follows a complete, accepted erase or write form, and it runs to its end even if select stays low throughout.
- R7: Erase sets the addressed word to 16'hFFFF; erase-all sets every word to 16'hFFFF.
- R8: Write sets the addressed word to the data word; write-all sets every word to the data word.
- R9: The output enable is low during reset and whenever select is low. With select high after a program cycle was launched, the output is enabled and reads 0 while busy and 1 once done, until the next start bit.
- R10: A start bit that arrives while a program cycle runs is ignored, and the rest of that instruction has no effect.
- R11: Once an instruction has all its bits, further serial clocks and data-in values are ignored until select goes low.
- R12: The busy time is WORD_TICKS system clocks for erase, write and erase-all, and BULK_TICKS for write-all.
- R13: Enable stays in force across instructions until a disable runs. After a disable, erase and write are ignored again, while reads still work.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, active high, asynchronous to clk |
| sckIn | input | 1 | Serial clock, asynchronous to clk |
| diIn | input | 1 | Serial data in, asynchronous to clk |
| doOut | output | 1 | Serial data out: read data or ready/busy level |
| doOe | output | 1 | Output enable for doOut |

## Verification
A rising serial-clock edge reaches the decoder two system clocks after it is driven, and the new serial output bit is registered on the next edge. The bench therefore holds each serial half period for six system clocks and samples the output just before the serial clock falls. Busy starts about two system clocks after select falls. The bench checks the busy level shortly after select is raised again, checks again about forty clocks before the cycle should end, and expects ready about thirty clocks after the end. Those margins separate WORD_TICKS from BULK_TICKS without depending on the exact clock of the end.

// File: rtl/mwire_eeprom_pkg.sv
package mwire_eeprom_pkg;

  // Opcode field values, first two bits after the start bit.
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  // Extended function codes, top two bits of the address field.
  localparam logic [1:0] EX_DIS  = 2'b00;
  localparam logic [1:0] EX_WRAL = 2'b01;
  localparam logic [1:0] EX_ERAL = 2'b10;
  localparam logic [1:0] EX_EN   = 2'b11;

  typedef enum logic [2:0] {
    PK_NONE,
    PK_ERASE,
    PK_ERASE_ALL,
    PK_WRITE,
    PK_WRITE_ALL
  } progKind_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic      loadRd;
    logic      shiftRd;
    logic      progGo;
    progKind_t kind;
  } dpCmd_t;

endpackage

// File: rtl/mwire_eeprom_sync.sv
module mwire_eeprom_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/mwire_eeprom_ctrl.sv
module mwire_eeprom_ctrl
  import mwire_eeprom_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int WORD_TICKS = 300000,
  parameter int BULK_TICKS = 750000,
  parameter int TIMER_W    = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csLive,
  input  logic               sckLive,
  input  logic               diLive,
  output dpCmd_t             cmd,
  output logic [ADDR_W-1:0]  addrOut,
  output logic [DATA_W-1:0]  dataOut,
  output logic               busy,
  output logic               statusOn,
  output logic               reading,
  output logic               wen,
  output logic [TIMER_W-1:0] progTimer
);

  localparam int FieldW   = ADDR_W + 1;
  localparam int HdrBits  = 2 + FieldW;
  localparam int FullBits = HdrBits + DATA_W;
  localparam int CntW     = $clog2(FullBits + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_READ, ST_DONE} state_t;

  state_t               state;
  logic [CntW-1:0]      bitCnt;
  logic [FullBits-2:0]  shReg;
  logic [FullBits-1:0]  shNext;
  progKind_t            pend;
  progKind_t            fullKind;
  logic [ADDR_W-1:0]    pendAddr;
  logic [DATA_W-1:0]    pendData;
  logic                 csPrev, sckPrev, sckRise, csFall;
  logic [1:0]           hdrOp, hdrExt, fullOp, fullExt;
  logic [ADDR_W-1:0]    hdrAddr, fullAddr;
  logic [DATA_W-1:0]    fullData;
  logic                 hdrLast, fullLast;

  assign sckRise  = sckLive & ~sckPrev;
  assign csFall   = csPrev & ~csLive;
  assign shNext   = {shReg, diLive};

  assign hdrOp    = shNext[HdrBits-1 -: 2];
  assign hdrExt   = shNext[FieldW-1 -: 2];
  assign hdrAddr  = shNext[ADDR_W-1:0];
  assign fullOp   = shNext[FullBits-1 -: 2];
  assign fullExt  = shNext[DATA_W+FieldW-1 -: 2];
  assign fullAddr = shNext[DATA_W +: ADDR_W];
  assign fullData = shNext[DATA_W-1:0];

  assign hdrLast  = (state == ST_SHIFT) && csLive && sckRise && (bitCnt == CntW'(HdrBits - 1));
  assign fullLast = (state == ST_SHIFT) && csLive && sckRise && (bitCnt == CntW'(FullBits - 1));

  assign busy     = (progTimer != '0);
  assign reading  = (state == ST_READ);

  always_comb begin
    if (fullOp == OP_WRITE)                         fullKind = PK_WRITE;
    else if (fullOp == OP_EXT && fullExt == EX_WRAL) fullKind = PK_WRITE_ALL;
    else                                             fullKind = PK_NONE;
  end

  always_comb begin
    cmd.loadRd  = hdrLast && (hdrOp == OP_READ);
    cmd.shiftRd = reading && csLive && sckRise;
    cmd.progGo  = csFall && (pend != PK_NONE) && !busy;
    cmd.kind    = pend;
    addrOut     = cmd.progGo ? pendAddr : hdrAddr;
    dataOut     = pendData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shReg     <= '0;
      pend      <= PK_NONE;
      pendAddr  <= '0;
      pendData  <= '0;
      wen       <= 1'b0;
      progTimer <= '0;
      statusOn  <= 1'b0;
      csPrev    <= 1'b0;
      sckPrev   <= 1'b0;
    end else begin
      csPrev  <= csLive;
      sckPrev <= sckLive;

      if (cmd.progGo)
        progTimer <= (pend == PK_WRITE_ALL) ? TIMER_W'(BULK_TICKS) : TIMER_W'(WORD_TICKS);
      else if (busy)
        progTimer <= progTimer - 1'b1;

      if (!csLive) begin
        state <= ST_IDLE;
        pend  <= PK_NONE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (sckRise && diLive && !busy) begin
              state    <= ST_SHIFT;
              bitCnt   <= '0;
              shReg    <= '0;
              statusOn <= 1'b0;
            end
          end
          ST_SHIFT: begin
            if (sckRise) begin
              shReg  <= shNext[FullBits-2:0];
              bitCnt <= bitCnt + 1'b1;
              if (hdrLast) begin
                case (hdrOp)
                  OP_READ: state <= ST_READ;
                  OP_ERASE: begin
                    if (wen) begin
                      pend     <= PK_ERASE;
                      pendAddr <= hdrAddr;
                    end
                    state <= ST_DONE;
                  end
                  OP_EXT: begin
                    case (hdrExt)
                      EX_EN:   begin wen <= 1'b1; state <= ST_DONE; end
                      EX_DIS:  begin wen <= 1'b0; state <= ST_DONE; end
                      EX_ERAL: begin
                        if (wen) pend <= PK_ERASE_ALL;
                        state <= ST_DONE;
                      end
                      default: ;
                    endcase
                  end
                  default: ;
                endcase
              end
              if (fullLast) begin
                if (wen) pend <= fullKind;
                pendAddr <= fullAddr;
                pendData <= fullData;
                state    <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end

      if (cmd.progGo) statusOn <= 1'b1;
    end
  end

endmodule

// File: rtl/mwire_eeprom_dp.sv
module mwire_eeprom_dp
  import mwire_eeprom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              csLive,
  input  logic              busy,
  input  logic              statusOn,
  input  logic              reading,
  output logic              doOut,
  output logic              doOe
);

  localparam int Words   = 1 << ADDR_W;
  localparam int RdCntW  = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] mem [Words];
  logic [ADDR_W-1:0] rdAddr, rdAddrInc;
  logic [DATA_W-1:0] rdShift, nextWord;
  logic [RdCntW-1:0] rdCnt;
  logic              outBit;

  assign rdAddrInc = rdAddr + 1'b1;
  assign nextWord  = mem[rdAddrInc];

  // Array: the whole programming effect lands at launch; the timer only models duration.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < Words; i++) mem[i] <= '1;
    end else if (cmd.progGo) begin
      case (cmd.kind)
        PK_ERASE:     mem[addrIn] <= '1;
        PK_WRITE:     mem[addrIn] <= dataIn;
        PK_ERASE_ALL: for (int i = 0; i < Words; i++) mem[i] <= '1;
        PK_WRITE_ALL: for (int i = 0; i < Words; i++) mem[i] <= dataIn;
        default: ;
      endcase
    end
  end

  // Read shifter: dummy zero on load, then MSB first, rolling to the next word.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr  <= '0;
      rdShift <= '0;
      rdCnt   <= '0;
      outBit  <= 1'b0;
    end else if (cmd.loadRd) begin
      rdAddr  <= addrIn;
      rdShift <= mem[addrIn];
      rdCnt   <= '0;
      outBit  <= 1'b0;
    end else if (cmd.shiftRd) begin
      if (rdCnt == RdCntW'(DATA_W)) begin
        rdAddr  <= rdAddrInc;
        outBit  <= nextWord[DATA_W-1];
        rdShift <= {nextWord[DATA_W-2:0], 1'b0};
        rdCnt   <= RdCntW'(1);
      end else begin
        outBit  <= rdShift[DATA_W-1];
        rdShift <= rdShift << 1;
        rdCnt   <= rdCnt + 1'b1;
      end
    end
  end

  assign doOe  = csLive & (reading | statusOn);
  assign doOut = reading ? outBit : ~busy;

endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom
  import mwire_eeprom_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int WORD_TICKS = 300000,
  parameter int BULK_TICKS = 750000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sckIn,
  input  logic diIn,
  output logic doOut,
  output logic doOe
);

  localparam int TickMax = (WORD_TICKS > BULK_TICKS) ? WORD_TICKS : BULK_TICKS;
  localparam int TimerW  = $clog2(TickMax + 1);

  logic               csLive, sckLive, diLive;
  dpCmd_t             cmd;
  logic [ADDR_W-1:0]  addrBus;
  logic [DATA_W-1:0]  dataBus;
  logic               busy, statusOn, reading, wen;
  logic [TimerW-1:0]  progTimer;

  mwire_eeprom_sync #(.WIDTH(3), .STAGES(2)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({csIn, sckIn, diIn}),
    .dout ({csLive, sckLive, diLive})
  );

  mwire_eeprom_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WORD_TICKS(WORD_TICKS), .BULK_TICKS(BULK_TICKS), .TIMER_W(TimerW)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .csLive(csLive), .sckLive(sckLive), .diLive(diLive),
    .cmd(cmd), .addrOut(addrBus), .dataOut(dataBus),
    .busy(busy), .statusOn(statusOn), .reading(reading),
    .wen(wen), .progTimer(progTimer)
  );

  mwire_eeprom_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .addrIn(addrBus), .dataIn(dataBus),
    .csLive(csLive), .busy(busy), .statusOn(statusOn), .reading(reading),
    .doOut(doOut), .doOe(doOe)
  );

endmodule

// File: rtl/mwire_eeprom_chk.sv
module mwire_eeprom_chk
  import mwire_eeprom_pkg::*;
#(
  parameter int TIMER_W = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               csIn,
  input logic               doOut,
  input logic               doOe,
  input logic               busy,
  input logic               wen,
  input logic [TIMER_W-1:0] progTimer,
  input dpCmd_t             cmd
);

  // R9: three cycles of select low at the pin must silence the output.
  p_oe_cs_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!csIn && $past(!csIn) && $past(!csIn, 2)) |-> !doOe);

  // R6: while a cycle runs, an enabled output reads busy.
  p_busy_reads_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && doOe) |-> !doOut);

  // R6: a launch always carries a real operation.
  p_launch_kind_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.progGo |-> (cmd.kind != PK_NONE));

  // R3: programming launches only while enabled.
  p_launch_enabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.progGo |-> wen);

  // R10: no read begins during a program cycle.
  p_no_read_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmd.loadRd);

  // R12: the cycle timer counts down by one each clock once loaded.
  p_timer_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(progTimer) != '0 && !$past(cmd.progGo)) |-> (progTimer == $past(progTimer) - 1'b1));

  // R2: datapath strobes are mutually exclusive.
  p_strobes_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadRd, cmd.shiftRd, cmd.progGo}));

endmodule

bind mwire_eeprom mwire_eeprom_chk #(.TIMER_W(TimerW)) uChk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .doOut(doOut), .doOe(doOe),
  .busy(busy), .wen(wen), .progTimer(progTimer), .cmd(cmd)
);

// File: tb/sim_mwire_eeprom.sv
module sim_mwire_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WORD_T     = 300;
  localparam int BULK_T     = 700;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0, sckIn = 1'b0, diIn = 1'b0;
  logic doOut, doOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwire_eeprom #(.ADDR_W(7), .DATA_W(16), .WORD_TICKS(WORD_T), .BULK_TICKS(BULK_T)) u0 (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sckIn(sckIn), .diIn(diIn),
    .doOut(doOut), .doOe(doOe)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] refMem [128];
  bit refWen = 0;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic waitSys(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b, output logic s);
    diIn = b;
    waitSys(HALF);
    sckIn = 1'b1;
    waitSys(HALF);
    s = doOut;
    sckIn = 1'b0;
  endtask

  task automatic sendField(logic [31:0] v, int n);
    logic s;
    for (int i = n - 1; i >= 0; i--) sendBit(v[i], s);
  endtask

  task automatic selectOn();
    csIn = 1'b1;
    waitSys(4);
  endtask

  task automatic selectOff();
    csIn = 1'b0;
    diIn = 1'b0;
    waitSys(4);
  endtask

  function automatic logic [15:0] modelRead(int a);
    return refMem[a % 128];
  endfunction

  // Sends one instruction and drops select; the model follows R2/R3/R7/R8/R13.
  task automatic issue(logic [1:0] op, logic [7:0] field, logic [15:0] data, int extra, bit modelIt);
    logic s;
    selectOn();
    sendBit(1'b1, s);
    sendField({30'd0, op}, 2);
    sendField({24'd0, field}, 8);
    if (op == 2'b01 || (op == 2'b00 && field[7:6] == 2'b01)) sendField({16'd0, data}, 16);
    for (int i = 0; i < extra; i++) sendBit(1'b1, s);
    csIn = 1'b0;
    diIn = 1'b0;
    if (modelIt) begin
      case (op)
        2'b00: case (field[7:6])
          2'b11: refWen = 1;
          2'b00: refWen = 0;
          2'b10: if (refWen) for (int i = 0; i < 128; i++) refMem[i] = 16'hFFFF;
          default: if (refWen) for (int i = 0; i < 128; i++) refMem[i] = data;
        endcase
        2'b01: if (refWen) refMem[field[6:0]] = data;
        2'b11: if (refWen) refMem[field[6:0]] = 16'hFFFF;
        default: ;
      endcase
    end
  endtask

  // Called right after issue(): checks busy early and late, then ready (R6, R9, R12).
  task automatic statusCheck(int ticks, string tag);
    waitSys(4);
    csIn = 1'b1;
    waitSys(5);
    chk({tag, " busy early"}, {14'd0, doOe, doOut}, 16'd2);
    waitSys(ticks - 50);
    chk({tag, " busy late"}, {14'd0, doOe, doOut}, 16'd2);
    waitSys(70);
    chk({tag, " ready"}, {14'd0, doOe, doOut}, 16'd3);
    csIn = 1'b0;
    waitSys(4);
  endtask

  task automatic doRead(logic [6:0] addr, int nWords, int lead, string tag);
    logic s;
    logic [15:0] w;
    selectOn();
    for (int i = 0; i < lead; i++) sendBit(1'b0, s);
    sendBit(1'b1, s);
    sendField(32'b10, 2);
    sendBit($urandom_range(0, 1), s);
    for (int i = 6; i >= 1; i--) sendBit(addr[i], s);
    sendBit(addr[0], s);
    chk({tag, " R4 dummy zero"}, {15'd0, s}, 16'd0);
    for (int k = 0; k < nWords; k++) begin
      for (int b = 15; b >= 0; b--) begin
        sendBit(1'b0, s);
        w[b] = s;
      end
      chk({tag, " R4 R5 word"}, w, modelRead(int'(addr) + k));
    end
    selectOff();
  endtask

  initial begin
    logic [6:0] a, a2;
    logic [15:0] d;
    for (int i = 0; i < 128; i++) refMem[i] = 16'hFFFF;
    void'($urandom(32'd4177));
    waitSys(6);
    chk("R9 reset output enable", {15'd0, doOe}, 16'd0);
    rstN = 1'b1;
    waitSys(4);
    chk("R9 idle output enable", {15'd0, doOe}, 16'd0);

    // R3: write before enable is dropped and starts no cycle.
    issue(2'b01, 8'h05, 16'h1234, 0, 1);
    waitSys(4);
    csIn = 1'b1;
    waitSys(5);
    chk("R3 no status after locked write", {15'd0, doOe}, 16'd0);
    csIn = 1'b0;
    waitSys(4);
    doRead(7'h05, 1, 0, "R3 locked word");

    // R13 / R2: enable, then write with status and readback (R8, R12).
    issue(2'b00, 8'hC0, 16'h0, 0, 1);
    waitSys(4);
    issue(2'b01, 8'h85, 16'hA5C3, 0, 1);
    statusCheck(WORD_T, "R12 write");
    doRead(7'h05, 1, 0, "R8 write");

    // Random writes with don't-care field MSB (R2, R8).
    for (int n = 0; n < 8; n++) begin
      a = 7'($urandom_range(0, 127));
      d = 16'($urandom);
      issue(2'b01, {1'($urandom_range(0, 1)), a}, d, 0, 1);
      waitSys(WORD_T + 30);
      doRead(a, 1, 0, "R8 random write");
    end

    // Sequential read across the wrap (R5).
    issue(2'b01, 8'h7F, 16'h8001, 0, 1); waitSys(WORD_T + 30);
    issue(2'b01, 8'h00, 16'h7EFE, 0, 1); waitSys(WORD_T + 30);
    doRead(7'h7E, 4, 0, "R5 wrap");

    // R1: clocks with data-in low before the start bit.
    doRead(7'h00, 1, 5, "R1 leading zeros");

    // R7: erase of one word.
    issue(2'b11, 8'h05, 16'h0, 0, 1);
    statusCheck(WORD_T, "R12 erase");
    doRead(7'h05, 1, 0, "R7 erase");

    // R11: trailing clocks with data-in high after a full write.
    issue(2'b01, 8'h22, 16'h5AA5, 5, 1);
    waitSys(WORD_T + 30);
    doRead(7'h22, 1, 0, "R11 trailing bits");

    // R10: instruction during busy is ignored.
    a = 7'h31; a2 = 7'h32;
    issue(2'b01, {1'b0, a}, 16'h1111, 0, 1);
    waitSys(4);
    issue(2'b01, {1'b0, a2}, 16'h2222, 0, 0);
    waitSys(WORD_T + 30);
    doRead(a2, 1, 0, "R10 ignored while busy");
    doRead(a, 1, 0, "R10 first write kept");

    // R6 / R9: select held low for the whole cycle.
    issue(2'b01, 8'h40, 16'hBEEF, 0, 1);
    waitSys(20);
    chk("R9 oe low while cs low and busy", {15'd0, doOe}, 16'd0);
    waitSys(WORD_T + 20);
    csIn = 1'b1;
    waitSys(5);
    chk("R6 R9 ready after low-cs cycle", {14'd0, doOe, doOut}, 16'd3);
    csIn = 1'b0;
    waitSys(4);
    doRead(7'h40, 1, 0, "R6 completed write");

    // Write-all with the longer cycle (R8, R12).
    issue(2'b00, 8'h40, 16'h3C3C, 0, 1);
    statusCheck(BULK_T, "R12 write-all");
    for (int n = 0; n < 3; n++) doRead(7'($urandom_range(0, 127)), 1, 0, "R8 write-all");

    // Erase-all (R7).
    issue(2'b00, 8'h80, 16'h0, 0, 1);
    statusCheck(WORD_T, "R12 erase-all");
    doRead(7'h7F, 2, 0, "R7 erase-all");

    // R13: disable, then write and erase are ignored, reads still work.
    issue(2'b01, 8'h10, 16'h0F0F, 0, 1); waitSys(WORD_T + 30);
    issue(2'b00, 8'h00, 16'h0, 0, 1); waitSys(4);
    issue(2'b01, 8'h10, 16'hF00F, 0, 1); waitSys(WORD_T + 30);
    issue(2'b11, 8'h10, 16'h0, 0, 1); waitSys(WORD_T + 30);
    doRead(7'h10, 1, 0, "R13 after disable");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule